// File: doc/BRIEF.md
# Two-Level Preemptive Priority Conversion Arbiter

This block decides which urgent single-channel conversion owns the shared converter while a background scan may be running. It has two request sources. The urgent source comes from an external trigger and is the higher level. The normal source comes from software or a timer and is the lower level. Each request names one channel. Every time a conversion is launched, the block issues a one-cycle request to the converter, together with the channel number and the level.

A single-entry pending slot holds at most one lower-level request. That request waits while an urgent conversion runs, and it is relaunched once the urgent conversion is done. While any priority conversion is active and the background scan is busy, the scan sequencer is told to pause. When the last priority conversion finishes, the sequencer gets a one-cycle resume pulse. A forced stop clears everything at once: the priority work, the pending slot and the scan-busy state.

All outputs are registered state, or simple combinations of that state, so every response appears on the clock edge that follows the input.

Top module: `pconv_arb`

## Requirements
- R1: After reset, `prio_busy`, `pend`, `scan_busy`, `scan_pause`, `scan_resume` and `conv_req` are all 0, and `prio_lvl` is 0. The level encoding is: 0 = idle, 1 = urgent level, 2 = lower level.
- R2: When the arbiter is idle, a `lo_start` pulse makes these appear on the next edge: a one-cycle `conv_req`, `conv_ch` equal to `lo_ch`, `prio_lvl` = 2 and `prio_busy` = 1.
- R3: A `hi_start` pulse when idle, or while a lower-level conversion runs, launches `hi_ch` at `prio_lvl` = 1 on the next edge. When both starts arrive together while idle, the urgent one is launched.
- R4: When an urgent start preempts a running lower-level conversion, the interrupted channel is placed in the pending slot (`pend` = 1). When the urgent conversion completes, that channel is relaunched at level 2 and `pend` returns to 0.
- R5: A `lo_start` during an urgent conversion sets `pend` and stores its channel. Any further `lo_start` while the slot is full is merged into it, and the first stored channel is kept. `pend` is only ever 1 while `prio_lvl` = 1.
- R6: A start of the same level as the running conversion restarts that conversion with the new channel and issues a fresh `conv_req`, with no effect on `pend`.
- R7: When `conv_done` ends a conversion and nothing is pending, `prio_lvl` goes to 0. If `scan_busy` is 1, `scan_resume` pulses for exactly one cycle.
- R8: `scan_start` sets `scan_busy` and `scan_end` clears it. `scan_pause` is 1 exactly while `scan_busy` and `prio_busy` are both 1.
- R9: `force_stop` has precedence over every same-cycle input. On the next edge, `prio_busy`, `pend` and `scan_busy` are all 0, and no `conv_req` or `scan_resume` is issued.
- R10: A `conv_done` while the arbiter is idle has no effect.
- R11: When `conv_done` and a start arrive in the same cycle, the completion is applied first, and the start is then judged against the resulting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_start | input | 1 | Urgent (external trigger) start pulse |
| hi_ch | input | CH_W | Channel for the urgent start |
| lo_start | input | 1 | Lower-level (software/timer) start pulse |
| lo_ch | input | CH_W | Channel for the lower-level start |
| conv_done | input | 1 | Converter finished the current priority conversion |
| force_stop | input | 1 | Forced stop of all conversion activity |
| scan_start | input | 1 | Background scan has started |
| scan_end | input | 1 | Background scan has ended |
| conv_req | output | 1 | One-cycle launch request to the converter |
| conv_ch | output | CH_W | Channel of the running priority conversion |
| prio_lvl | output | 2 | Active level: 0 idle, 1 urgent, 2 lower |
| prio_busy | output | 1 | A priority conversion is active |
| pend | output | 1 | Pending slot holds a lower-level request |
| scan_busy | output | 1 | Background scan is in progress |
| scan_pause | output | 1 | Scan sequencer must hold |
| scan_resume | output | 1 | One-cycle pulse letting the scan continue |

## Verification
The arbitration is driven with these patterns, each of which separates a different ordering rule:
- A lower-level start alone.
- An urgent start on top of a running lower-level conversion. This separates preemption from queuing.
- Repeated lower-level starts during an urgent conversion. This separates merging from overwriting the slot.
- Same-level restarts.
- Simultaneous urgent and lower-level starts.

Completion pulses that coincide with new starts show whether the completion is applied before the start. A forced stop given together with a start shows whether the stop takes precedence. Idle completions and resume pulses with and without a busy scan show that the pause/resume handshake fires only when the scan is really waiting.

// File: rtl/pconv_pkg.sv
package pconv_pkg;

  typedef enum logic [1:0] {
    LV_IDLE = 2'd0,
    LV_HI   = 2'd1,
    LV_LO   = 2'd2
  } lvl_e;

  // True when a level holds the converter.
  function automatic logic lvl_active(input lvl_e l);
    return l != LV_IDLE;
  endfunction

  // An urgent start displaces a lower-level conversion.
  function automatic logic hi_preempts(input lvl_e l);
    return l == LV_LO;
  endfunction

  // A lower-level start begins at once only when the converter is free.
  function automatic logic lo_direct(input lvl_e l);
    return l == LV_IDLE;
  endfunction

endpackage

// File: rtl/pconv_level_ctrl.sv
module pconv_level_ctrl
  import pconv_pkg::*;
#(
  parameter int CH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            force_stop,
  input  logic            hi_start,
  input  logic [CH_W-1:0] hi_ch,
  input  logic            lo_start,
  input  logic [CH_W-1:0] lo_ch,
  input  logic            conv_done,
  input  logic            pend_q,
  input  logic [CH_W-1:0] pend_ch,
  output lvl_e            lvl_q,
  output logic [CH_W-1:0] ch_q,
  output logic            req_q,
  output logic            pend_set,
  output logic [CH_W-1:0] pend_set_ch,
  output logic            pend_take,
  output logic            went_idle
);

  lvl_e            s_lvl;
  logic [CH_W-1:0] s_ch;
  logic            launch;
  logic            pend_live;

  always_comb begin
    s_lvl       = lvl_q;
    s_ch        = ch_q;
    launch      = 1'b0;
    pend_set    = 1'b0;
    pend_set_ch = lo_ch;
    pend_take   = 1'b0;

    // Step 1: completion of the running conversion.
    if (conv_done && lvl_active(lvl_q)) begin
      if (pend_q) begin
        s_lvl     = LV_LO;
        s_ch      = pend_ch;
        pend_take = 1'b1;
        launch    = 1'b1;
      end else begin
        s_lvl = LV_IDLE;
      end
    end
    pend_live = pend_q && !pend_take;

    // Step 2: urgent start, judged after completion.
    if (hi_start) begin
      if (hi_preempts(s_lvl)) begin
        pend_set    = 1'b1;
        pend_set_ch = s_ch;
      end
      s_lvl  = LV_HI;
      s_ch   = hi_ch;
      launch = 1'b1;
    end

    // Step 3: lower-level start.
    if (lo_start) begin
      if (lo_direct(s_lvl) || s_lvl == LV_LO) begin
        s_lvl  = LV_LO;
        s_ch   = lo_ch;
        launch = 1'b1;
      end else if (pend_set) begin
        pend_set_ch = lo_ch;
      end else if (!pend_live) begin
        pend_set    = 1'b1;
        pend_set_ch = lo_ch;
      end
    end

    if (force_stop) begin
      s_lvl     = LV_IDLE;
      launch    = 1'b0;
      pend_set  = 1'b0;
      pend_take = 1'b0;
    end
  end

  assign went_idle = !force_stop && lvl_active(lvl_q) && !lvl_active(s_lvl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= LV_IDLE;
      ch_q  <= '0;
      req_q <= 1'b0;
    end else begin
      lvl_q <= s_lvl;
      ch_q  <= s_ch;
      req_q <= launch;
    end
  end

endmodule

// File: rtl/pconv_pend_slot.sv
module pconv_pend_slot #(
  parameter int CH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            force_stop,
  input  logic            pend_set,
  input  logic [CH_W-1:0] pend_set_ch,
  input  logic            pend_take,
  output logic            pend_q,
  output logic [CH_W-1:0] pend_ch
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      pend_ch <= '0;
    end else if (force_stop) begin
      pend_q <= 1'b0;
    end else if (pend_set) begin
      pend_q  <= 1'b1;
      pend_ch <= pend_set_ch;
    end else if (pend_take) begin
      pend_q <= 1'b0;
    end
  end

endmodule

// File: rtl/pconv_scan_track.sv
module pconv_scan_track (
  input  logic clk,
  input  logic rst_n,
  input  logic force_stop,
  input  logic scan_start,
  input  logic scan_end,
  input  logic prio_active,
  input  logic went_idle,
  output logic scan_busy_q,
  output logic scan_pause,
  output logic resume_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_busy_q <= 1'b0;
      resume_q    <= 1'b0;
    end else begin
      resume_q <= went_idle && scan_busy_q;
      if (force_stop)      scan_busy_q <= 1'b0;
      else if (scan_start) scan_busy_q <= 1'b1;
      else if (scan_end)   scan_busy_q <= 1'b0;
    end
  end

  assign scan_pause = scan_busy_q && prio_active;

endmodule

// File: rtl/pconv_arb.sv
module pconv_arb
  import pconv_pkg::*;
#(
  parameter int CH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hi_start,
  input  logic [CH_W-1:0] hi_ch,
  input  logic            lo_start,
  input  logic [CH_W-1:0] lo_ch,
  input  logic            conv_done,
  input  logic            force_stop,
  input  logic            scan_start,
  input  logic            scan_end,
  output logic            conv_req,
  output logic [CH_W-1:0] conv_ch,
  output logic [1:0]      prio_lvl,
  output logic            prio_busy,
  output logic            pend,
  output logic            scan_busy,
  output logic            scan_pause,
  output logic            scan_resume
);

  lvl_e            lvl_q;
  logic            pend_q;
  logic [CH_W-1:0] pend_ch;
  logic            pend_set;
  logic [CH_W-1:0] pend_set_ch;
  logic            pend_take;
  logic            went_idle;

  pconv_level_ctrl #(.CH_W(CH_W)) u_level (
    .clk        (clk),
    .rst_n      (rst_n),
    .force_stop (force_stop),
    .hi_start   (hi_start),
    .hi_ch      (hi_ch),
    .lo_start   (lo_start),
    .lo_ch      (lo_ch),
    .conv_done  (conv_done),
    .pend_q     (pend_q),
    .pend_ch    (pend_ch),
    .lvl_q      (lvl_q),
    .ch_q       (conv_ch),
    .req_q      (conv_req),
    .pend_set   (pend_set),
    .pend_set_ch(pend_set_ch),
    .pend_take  (pend_take),
    .went_idle  (went_idle)
  );

  pconv_pend_slot #(.CH_W(CH_W)) u_pend (
    .clk        (clk),
    .rst_n      (rst_n),
    .force_stop (force_stop),
    .pend_set   (pend_set),
    .pend_set_ch(pend_set_ch),
    .pend_take  (pend_take),
    .pend_q     (pend_q),
    .pend_ch    (pend_ch)
  );

  pconv_scan_track u_scan (
    .clk        (clk),
    .rst_n      (rst_n),
    .force_stop (force_stop),
    .scan_start (scan_start),
    .scan_end   (scan_end),
    .prio_active(prio_busy),
    .went_idle  (went_idle),
    .scan_busy_q(scan_busy),
    .scan_pause (scan_pause),
    .resume_q   (scan_resume)
  );

  assign prio_lvl  = lvl_q;
  assign prio_busy = lvl_active(lvl_q);
  assign pend      = pend_q;

endmodule

// File: rtl/pconv_arb_checker.sv
module pconv_arb_checker #(
  parameter int CH_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hi_start,
  input logic [CH_W-1:0] hi_ch,
  input logic            lo_start,
  input logic            conv_done,
  input logic            force_stop,
  input logic            conv_req,
  input logic [CH_W-1:0] conv_ch,
  input logic [1:0]      prio_lvl,
  input logic            prio_busy,
  input logic            pend,
  input logic            scan_busy,
  input logic            scan_resume
);

  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> prio_busy); // R2

  AST_HI_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_start && !force_stop) |=> (conv_req && prio_lvl == 2'd1 && conv_ch == $past(hi_ch))); // R3

  AST_PREEMPT_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_start && !force_stop && !conv_done && prio_lvl == 2'd2) |=> pend); // R4

  AST_PEND_UNDER_HI: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> prio_lvl == 2'd1); // R5

  AST_RESUME_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    scan_resume |-> (!prio_busy && $past(prio_busy) && $past(scan_busy))); // R7

  AST_RESUME_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    scan_resume |=> !scan_resume); // R7

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    force_stop |=> (!prio_busy && !pend && !scan_busy && !conv_req && !scan_resume)); // R9

  AST_IDLE_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !prio_busy && !hi_start && !lo_start) |=> (!prio_busy && !conv_req)); // R10

endmodule

bind pconv_arb pconv_arb_checker #(.CH_W(CH_W)) u_pconv_arb_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .hi_start   (hi_start),
  .hi_ch      (hi_ch),
  .lo_start   (lo_start),
  .conv_done  (conv_done),
  .force_stop (force_stop),
  .conv_req   (conv_req),
  .conv_ch    (conv_ch),
  .prio_lvl   (prio_lvl),
  .prio_busy  (prio_busy),
  .pend       (pend),
  .scan_busy  (scan_busy),
  .scan_resume(scan_resume)
);

// File: tb/test_pconv_arb.sv
module test_pconv_arb;

  localparam int CH_W = 5;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            hi_start, lo_start, conv_done, force_stop, scan_start, scan_end;
  logic [CH_W-1:0] hi_ch, lo_ch;
  logic            conv_req, prio_busy, pend, scan_busy, scan_pause, scan_resume;
  logic [CH_W-1:0] conv_ch;
  logic [1:0]      prio_lvl;

  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  pconv_arb #(.CH_W(CH_W)) i_pconv_arb (
    .clk(clk), .rst_n(rst_n),
    .hi_start(hi_start), .hi_ch(hi_ch), .lo_start(lo_start), .lo_ch(lo_ch),
    .conv_done(conv_done), .force_stop(force_stop),
    .scan_start(scan_start), .scan_end(scan_end),
    .conv_req(conv_req), .conv_ch(conv_ch), .prio_lvl(prio_lvl),
    .prio_busy(prio_busy), .pend(pend), .scan_busy(scan_busy),
    .scan_pause(scan_pause), .scan_resume(scan_resume)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // Apply the currently driven inputs for one edge, then clear the pulses.
  task automatic tick();
    @(negedge clk);
    hi_start = 0; lo_start = 0; conv_done = 0; force_stop = 0;
    scan_start = 0; scan_end = 0;
  endtask

  task automatic expect_state(input string req, input int lvl, input int ch,
                              input int rq, input int pd);
    chk(req, "prio_lvl", prio_lvl, lvl);
    chk(req, "prio_busy", prio_busy, lvl != 0);
    if (lvl != 0) chk(req, "conv_ch", conv_ch, ch);
    chk(req, "conv_req", conv_req, rq);
    chk(req, "pend", pend, pd);
  endtask

  task automatic t_reset();
    expect_state("R1", 0, 0, 0, 0);
    chk("R1", "scan_busy", scan_busy, 0);
    chk("R1", "scan_pause", scan_pause, 0);
    chk("R1", "scan_resume", scan_resume, 0);
  endtask

  task automatic t_lo_idle();
    lo_start = 1; lo_ch = 3; tick();
    expect_state("R2", 2, 3, 1, 0);
    tick();
    expect_state("R2", 2, 3, 0, 0);
    conv_done = 1; tick();
    expect_state("R7", 0, 0, 0, 0);
    chk("R7", "scan_resume no scan", scan_resume, 0);
  endtask

  task automatic t_preempt();
    scan_start = 1; tick();
    chk("R8", "scan_busy", scan_busy, 1);
    chk("R8", "scan_pause idle", scan_pause, 0);
    lo_start = 1; lo_ch = 4; tick();
    chk("R8", "scan_pause", scan_pause, 1);
    hi_start = 1; hi_ch = 9; tick();
    expect_state("R3", 1, 9, 1, 1);
    conv_done = 1; tick();
    expect_state("R4", 2, 4, 1, 0);
    chk("R4", "no resume yet", scan_resume, 0);
    conv_done = 1; tick();
    expect_state("R7", 0, 0, 0, 0);
    chk("R7", "scan_resume", scan_resume, 1);
    chk("R8", "scan_pause off", scan_pause, 0);
    tick();
    chk("R7", "scan_resume single", scan_resume, 0);
    chk("R8", "scan_busy kept", scan_busy, 1);
    scan_end = 1; tick();
    chk("R8", "scan_busy cleared", scan_busy, 0);
  endtask

  task automatic t_merge();
    hi_start = 1; hi_ch = 1; tick();
    lo_start = 1; lo_ch = 6; tick();
    expect_state("R5", 1, 1, 0, 1);
    lo_start = 1; lo_ch = 7; tick();
    expect_state("R5", 1, 1, 0, 1);
    conv_done = 1; tick();
    expect_state("R5", 2, 6, 1, 0);
    conv_done = 1; tick();
    expect_state("R7", 0, 0, 0, 0);
  endtask

  task automatic t_restart();
    lo_start = 1; lo_ch = 2; tick();
    lo_start = 1; lo_ch = 5; tick();
    expect_state("R6", 2, 5, 1, 0);
    hi_start = 1; hi_ch = 10; tick();
    hi_start = 1; hi_ch = 11; tick();
    expect_state("R6", 1, 11, 1, 1);
    conv_done = 1; tick();
    expect_state("R4", 2, 5, 1, 0);
    conv_done = 1; tick();
  endtask

  task automatic t_both();
    hi_start = 1; hi_ch = 3; lo_start = 1; lo_ch = 8; tick();
    expect_state("R3", 1, 3, 1, 1);
    conv_done = 1; tick();
    expect_state("R3", 2, 8, 1, 0);
    conv_done = 1; tick();
    expect_state("R3", 0, 0, 0, 0);
  endtask

  task automatic t_stop();
    scan_start = 1; lo_start = 1; lo_ch = 2; tick();
    hi_start = 1; hi_ch = 3; tick();
    expect_state("R9", 1, 3, 1, 1);
    force_stop = 1; lo_start = 1; lo_ch = 4; tick();
    expect_state("R9", 0, 0, 0, 0);
    chk("R9", "scan_busy", scan_busy, 0);
    chk("R9", "scan_resume", scan_resume, 0);
    chk("R9", "scan_pause", scan_pause, 0);
    tick();
    chk("R9", "scan_resume later", scan_resume, 0);
    expect_state("R9", 0, 0, 0, 0);
  endtask

  task automatic t_done_idle();
    conv_done = 1; tick();
    expect_state("R10", 0, 0, 0, 0);
    chk("R10", "scan_resume", scan_resume, 0);
  endtask

  task automatic t_done_start();
    hi_start = 1; hi_ch = 1; tick();
    lo_start = 1; lo_ch = 2; tick();
    conv_done = 1; hi_start = 1; hi_ch = 12; tick();
    expect_state("R11", 1, 12, 1, 1);
    conv_done = 1; tick();
    expect_state("R11", 2, 2, 1, 0);
    scan_start = 1; tick();
    conv_done = 1; lo_start = 1; lo_ch = 14; tick();
    expect_state("R11", 2, 14, 1, 0);
    chk("R11", "no resume", scan_resume, 0);
    conv_done = 1; tick();
    chk("R11", "resume after end", scan_resume, 1);
    scan_end = 1; tick();
  endtask

  initial begin
    rst_n = 0;
    hi_start = 0; lo_start = 0; conv_done = 0; force_stop = 0;
    scan_start = 0; scan_end = 0; hi_ch = 0; lo_ch = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_lo_idle();
    t_preempt();
    t_merge();
    t_restart();
    t_both();
    t_stop();
    t_done_idle();
    t_done_start();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule